// File: doc/BRIEF.md
# Keyboard Scan Code to ASCII Translator

This block sits between a PS/2 keyboard receiver and a serial transmitter. It accepts one validated 8-bit scan code per strobe and turns key presses into ASCII characters for the 26 lowercase letters and the space bar. Release sequences, extended two-byte sequences and every key outside that set are consumed without producing output.

The keyboard resends the code of a held key at its own rate. The block ignores that stream and applies its own timing instead. A fresh press gives one character at once. If the key is still down after a hold interval, a second character follows, and another follows after each repeat interval until the key is released. Characters leave through a small queue with a valid/ready handshake, so a busy transmitter stalls the output and loses nothing. With the default parameters and a 50 MHz clock, the hold interval is 0.5 s and the repeat interval is 0.1 s.

Top module: `kbd_ascii_xlat`

## Requirements
- R1: After a synchronous reset, `char_valid` is low and no key is held.
- R2: Scan codes translate to ASCII as follows: a=0x1C, b=0x32, d=0x23, f=0x2B, g=0x34, s=0x1B (the full lowercase set-2 letter table) map to 0x61..0x7A, and the space code 0x29 maps to 0x20.
- R3: A press of a supported key that is not already held produces its character exactly once. The release pair 0xF0 followed by the key code produces nothing.
- R4: A code outside the supported set produces no character and leaves the held key and its timing unchanged.
- R5: After the prefix 0xE0, the next byte is discarded. After the pair 0xE0 0xF0, the byte that follows is also discarded.
- R6: A make code equal to the held key produces no character and does not restart the hold timing.
- R7: While a key stays held, a second character is pushed HOLD_CYCLES cycles after the first, and then one more every REPEAT_CYCLES cycles.
- R8: Pressing a different supported key while one is held emits the new character at once and restarts the hold timing for the new key. A later release of the old key has no effect.
- R9: While `char_ready` is low, `char_valid` and `char_data` stay stable. Up to QUEUE_DEPTH characters are kept in order. One further press arriving while the queue is full is kept back and delivered once space frees.
- R10: The release of the held key stops the repeat, and no further characters follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_valid | input | 1 | One-cycle strobe marking a received scan code |
| scan_code | input | 8 | Received scan code byte |
| char_valid | output | 1 | A character is offered to the transmitter |
| char_data | output | 8 | ASCII character offered |
| char_ready | input | 1 | Transmitter accepts the offered character this cycle |

## Verification
The bench targets the byte that follows a release or an extended prefix. A parser that loses its prefix state would print a stray letter there, for example an 'a' after 0xE0 0x1C. It also resends the held code in the middle of the hold window, and sends an unsupported code during a hold. A design that restarted its timer on either byte would move the second character later, and the bench measures each interval between handshakes to the cycle. Handing over to a new key and then releasing the old one checks that only the newest key drives the repeat. Filling the queue with the transmitter stalled, and then pressing one more key, exposes overflow, reordering and a dropped character.

// File: rtl/kbd_xlat_pkg.sv
package kbd_xlat_pkg;

    localparam logic [7:0] SC_RELEASE = 8'hF0;
    localparam logic [7:0] SC_EXTEND  = 8'hE0;

    typedef enum logic [1:0] {
        PFX_NONE,
        PFX_REL,
        PFX_EXT,
        PFX_EXT_REL
    } prefix_state_t;

    typedef enum logic {
        PH_FIRST,
        PH_REPEAT
    } rep_phase_t;

    typedef struct packed {
        logic       make;
        logic       brk;
        logic [7:0] code;
    } key_event_t;

    typedef struct packed {
        logic       hit;
        logic [7:0] ascii;
    } xlat_t;

    function automatic xlat_t scan_to_ascii(input logic [7:0] sc);
        xlat_t r;
        r.hit = 1'b1;
        case (sc)
            8'h1C: r.ascii = 8'h61; 8'h32: r.ascii = 8'h62; 8'h21: r.ascii = 8'h63;
            8'h23: r.ascii = 8'h64; 8'h24: r.ascii = 8'h65; 8'h2B: r.ascii = 8'h66;
            8'h34: r.ascii = 8'h67; 8'h33: r.ascii = 8'h68; 8'h43: r.ascii = 8'h69;
            8'h3B: r.ascii = 8'h6A; 8'h42: r.ascii = 8'h6B; 8'h4B: r.ascii = 8'h6C;
            8'h3A: r.ascii = 8'h6D; 8'h31: r.ascii = 8'h6E; 8'h44: r.ascii = 8'h6F;
            8'h4D: r.ascii = 8'h70; 8'h15: r.ascii = 8'h71; 8'h2D: r.ascii = 8'h72;
            8'h1B: r.ascii = 8'h73; 8'h2C: r.ascii = 8'h74; 8'h3C: r.ascii = 8'h75;
            8'h2A: r.ascii = 8'h76; 8'h1D: r.ascii = 8'h77; 8'h22: r.ascii = 8'h78;
            8'h35: r.ascii = 8'h79; 8'h1A: r.ascii = 8'h7A; 8'h29: r.ascii = 8'h20;
            default: begin
                r.hit   = 1'b0;
                r.ascii = 8'h00;
            end
        endcase
        return r;
    endfunction

    function automatic logic is_printable(input logic [7:0] a);
        return (a == 8'h20) || (a >= 8'h61 && a <= 8'h7A);
    endfunction

endpackage

// File: rtl/kbd_prefix_parser.sv
module kbd_prefix_parser
    import kbd_xlat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       code_valid,
    input  logic [7:0] code,
    output key_event_t ev
);

    prefix_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PFX_NONE;
            ev    <= '0;
        end else begin
            ev.make <= 1'b0;
            ev.brk  <= 1'b0;
            if (code_valid) begin
                ev.code <= code;
                case (state)
                    PFX_NONE: begin
                        if (code == SC_RELEASE)     state <= PFX_REL;
                        else if (code == SC_EXTEND) state <= PFX_EXT;
                        else                        ev.make <= 1'b1;
                    end
                    PFX_REL: begin
                        state  <= PFX_NONE;
                        ev.brk <= 1'b1;
                    end
                    PFX_EXT:     state <= (code == SC_RELEASE) ? PFX_EXT_REL : PFX_NONE;
                    PFX_EXT_REL: state <= PFX_NONE;
                    default:     state <= PFX_NONE;
                endcase
            end
        end
    end

    AST_EXT_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (code_valid && (state == PFX_EXT_REL)) |=> !ev.make && !ev.brk); // R5

    AST_EXT_NO_MAKE: assert property (@(posedge clk) disable iff (rst)
        (code_valid && (state == PFX_EXT)) |=> !ev.make); // R5

endmodule

// File: rtl/kbd_repeat_timer.sv
module kbd_repeat_timer
    import kbd_xlat_pkg::*;
#(
    parameter int HOLD_CYCLES   = 25_000_000,
    parameter int REPEAT_CYCLES = 5_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  key_event_t ev,
    input  logic       space,
    output logic       push,
    output logic [7:0] push_char
);

    localparam int MAX_CYC = (HOLD_CYCLES > REPEAT_CYCLES) ? HOLD_CYCLES : REPEAT_CYCLES;
    localparam int CW      = $clog2(MAX_CYC) + 1;
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);
    localparam logic [CW-1:0] REP_LAST  = CW'(REPEAT_CYCLES - 1);

    logic          held;
    logic [7:0]    held_code;
    logic [7:0]    held_ascii;
    logic [CW-1:0] cnt;
    rep_phase_t    phase;
    logic          pending;

    xlat_t         x;
    logic          new_press;
    logic          rel_held;
    logic          expired;

    always_comb begin
        x         = scan_to_ascii(ev.code);
        new_press = ev.make && x.hit && !(held && (ev.code == held_code));
        rel_held  = ev.brk && held && (ev.code == held_code);
        expired   = held && !rel_held &&
                    (cnt == ((phase == PH_FIRST) ? HOLD_LAST : REP_LAST));
        push      = space && (new_press || pending || expired);
        push_char = new_press ? x.ascii : held_ascii;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held       <= 1'b0;
            held_code  <= '0;
            held_ascii <= '0;
            cnt        <= '0;
            phase      <= PH_FIRST;
            pending    <= 1'b0;
        end else begin
            if (new_press)            pending <= !space;
            else if (pending && space) pending <= 1'b0;

            if (new_press) begin
                held       <= 1'b1;
                held_code  <= ev.code;
                held_ascii <= x.ascii;
                cnt        <= '0;
                phase      <= PH_FIRST;
            end else if (rel_held) begin
                held <= 1'b0;
                cnt  <= '0;
            end else if (held) begin
                if (expired) begin
                    if (space) begin
                        cnt   <= '0;
                        phase <= PH_REPEAT;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_PUSH_PRINTABLE: assert property (@(posedge clk) disable iff (rst)
        push |-> is_printable(push_char)); // R2

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rel_held && !new_press) |=> !held); // R10

    AST_NEW_KEY_TAKES: assert property (@(posedge clk) disable iff (rst)
        new_press |=> held && (held_code == $past(ev.code))); // R8

endmodule

// File: rtl/kbd_char_fifo.sv
module kbd_char_fifo #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [7:0] push_char,
    output logic       space,
    output logic       out_valid,
    output logic [7:0] out_char,
    input  logic       out_ready
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLN = CW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          pop;

    always_comb begin
        space     = (count != FULLN);
        out_valid = (count != '0);
        out_char  = mem[rd_ptr];
        pop       = out_valid && out_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_char;
                wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> (count != FULLN)); // R9

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_char)); // R9

endmodule

// File: rtl/kbd_ascii_xlat.sv
module kbd_ascii_xlat
    import kbd_xlat_pkg::*;
#(
    parameter int HOLD_CYCLES   = 25_000_000,
    parameter int REPEAT_CYCLES = 5_000_000,
    parameter int QUEUE_DEPTH   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scan_valid,
    input  logic [7:0] scan_code,
    output logic       char_valid,
    output logic [7:0] char_data,
    input  logic       char_ready
);

    key_event_t ev;
    logic       space;
    logic       push;
    logic [7:0] push_char;

    kbd_prefix_parser u_parser (
        .clk        (clk),
        .rst        (rst),
        .code_valid (scan_valid),
        .code       (scan_code),
        .ev         (ev)
    );

    kbd_repeat_timer #(
        .HOLD_CYCLES   (HOLD_CYCLES),
        .REPEAT_CYCLES (REPEAT_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .space     (space),
        .push      (push),
        .push_char (push_char)
    );

    kbd_char_fifo #(
        .DEPTH (QUEUE_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_char (push_char),
        .space     (space),
        .out_valid (char_valid),
        .out_char  (char_data),
        .out_ready (char_ready)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !char_valid); // R1

endmodule

// File: tb/kbd_ascii_xlat_bench.sv
`timescale 1ns/1ps
module kbd_ascii_xlat_bench;

    localparam int HOLD = 60;
    localparam int REP  = 12;
    localparam int QD   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_valid = 1'b0;
    logic [7:0] scan_code = 8'h00;
    logic       char_valid;
    logic [7:0] char_data;
    logic       char_ready = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int n_rx     = 0;
    logic [7:0] rx_chr [64];
    int         rx_at  [64];

    always #10 clk = ~clk;

    kbd_ascii_xlat #(
        .HOLD_CYCLES   (HOLD),
        .REPEAT_CYCLES (REP),
        .QUEUE_DEPTH   (QD)
    ) u_kbd_ascii_xlat (
        .clk        (clk),
        .rst        (rst),
        .scan_valid (scan_valid),
        .scan_code  (scan_code),
        .char_valid (char_valid),
        .char_data  (char_data),
        .char_ready (char_ready)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst && char_valid && char_ready && n_rx < 64) begin
            rx_chr[n_rx] = char_data;
            rx_at[n_rx]  = cyc;
            n_rx = n_rx + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] c);
        @(posedge clk); #1;
        scan_valid = 1'b1;
        scan_code  = c;
        @(posedge clk); #1;
        scan_valid = 1'b0;
    endtask

    task automatic tap(input logic [7:0] c);
        send(c); idle(3); send(8'hF0); send(c); idle(3);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        check(char_valid == 1'b0, "R1 reset valid", char_valid, 0);
        idle(5);
        check(n_rx == 0, "R1 no output after reset", n_rx, 0);
    endtask

    task automatic t_single_press;
        int b = n_rx;
        tap(8'h1C);
        idle(10);
        check(n_rx - b == 1, "R3 one char per press", n_rx - b, 1);
        check(rx_chr[b] == 8'h61, "R2 letter a", rx_chr[b], 8'h61);
        b = n_rx;
        tap(8'h29);
        idle(10);
        check(n_rx - b == 1, "R3 space one char", n_rx - b, 1);
        check(rx_chr[b] == 8'h20, "R2 space", rx_chr[b], 8'h20);
    endtask

    task automatic t_unsupported;
        int b = n_rx;
        tap(8'h12);
        tap(8'h05);
        idle(10);
        check(n_rx == b, "R4 unsupported ignored", n_rx - b, 0);
    endtask

    task automatic t_extended;
        int b = n_rx;
        send(8'hE0); send(8'h1C); idle(3);
        send(8'hE0); send(8'hF0); send(8'h1C); idle(3);
        send(8'hE0); send(8'h75); idle(3);
        send(8'hE0); send(8'hF0); send(8'h75); idle(10);
        check(n_rx == b, "R5 extended discarded", n_rx - b, 0);
        tap(8'h23);
        idle(8);
        check(n_rx - b == 1 && rx_chr[b] == 8'h64, "R5 parser recovers", rx_chr[b], 8'h64);
    endtask

    task automatic t_kbd_repeat;
        int b = n_rx;
        send(8'h1B);
        idle(15); send(8'h1B);
        idle(15); send(8'h1B);
        idle(15); send(8'hF0); send(8'h1B);
        idle(10);
        check(n_rx - b == 1, "R6 keyboard repeats ignored", n_rx - b, 1);
        check(rx_chr[b] == 8'h73, "R6 char s", rx_chr[b], 8'h73);
    endtask

    task automatic t_auto_repeat;
        int b = n_rx;
        send(8'h32);
        idle(20); send(8'h12);
        idle(15); send(8'h32);
        idle(HOLD + 3*REP + 6 - 38);
        send(8'hF0); send(8'h32);
        idle(2*HOLD);
        check(n_rx - b == 5, "R7 repeat count", n_rx - b, 5);
        check(rx_at[b+1] - rx_at[b] == HOLD, "R7 hold interval", rx_at[b+1] - rx_at[b], HOLD);
        for (int i = 2; i < 5; i++)
            check(rx_at[b+i] - rx_at[b+i-1] == REP, "R7 repeat interval",
                  rx_at[b+i] - rx_at[b+i-1], REP);
        for (int i = 0; i < 5; i++)
            check(rx_chr[b+i] == 8'h62, "R7 repeated char b", rx_chr[b+i], 8'h62);
        check(n_rx - b == 5, "R10 release stops repeat", n_rx - b, 5);
    endtask

    task automatic t_switch_key;
        int b = n_rx;
        send(8'h1C);
        idle(29);
        send(8'h32);
        idle(HOLD + 5);
        send(8'hF0); send(8'h1C);
        idle(REP - 2);
        send(8'hF0); send(8'h32);
        idle(2*HOLD);
        check(n_rx - b == 4, "R8 switch count", n_rx - b, 4);
        check(rx_chr[b] == 8'h61 && rx_chr[b+1] == 8'h62, "R8 new key emitted",
              rx_chr[b+1], 8'h62);
        check(rx_at[b+2] - rx_at[b+1] == HOLD, "R8 timing restarts",
              rx_at[b+2] - rx_at[b+1], HOLD);
        check(rx_at[b+3] - rx_at[b+2] == REP, "R8 old release no effect",
              rx_at[b+3] - rx_at[b+2], REP);
    endtask

    task automatic t_backpressure;
        int b = n_rx;
        logic [7:0] exp [5] = '{8'h61, 8'h73, 8'h64, 8'h66, 8'h67};
        char_ready = 1'b0;
        tap(8'h1C); tap(8'h1B); tap(8'h23); tap(8'h2B); tap(8'h34);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(char_valid == 1'b1 && char_data == 8'h61, "R9 held while stalled",
                  char_data, 8'h61);
        end
        idle(1);
        char_ready = 1'b1;
        idle(12);
        check(n_rx - b == 5, "R9 nothing dropped", n_rx - b, 5);
        for (int i = 0; i < 5; i++)
            check(rx_chr[b+i] == exp[i], "R9 order kept", rx_chr[b+i], exp[i]);
        check(char_valid == 1'b0, "R9 queue drains", char_valid, 0);
    endtask

    initial begin
        t_reset();
        t_single_press();
        t_unsupported();
        t_extended();
        t_kbd_repeat();
        t_auto_repeat();
        t_switch_key();
        t_backpressure();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule